// File: doc/BRIEF.md
# Serial Port Control and Interrupt Gating

This block holds the 8-bit control word of a serial port that runs in either asynchronous or clocked-synchronous framing. It turns that word into the transmit and receive enables and the clock-source selection. It also owns the three receive status flags (data ready, framing error, overrun) and combines the control bits with transmitter and receiver status to produce four level interrupt requests: transmit-data-empty, receive-data-full, receive-error and transmit-end.

A receiver reports each finished frame with a one-cycle strobe, qualified by its error indications and the value of the frame's multiprocessor bit. The transmitter supplies two level signals: data register empty and transmission end. Software writes the control word through a single write port and reads it back at any time. It clears status flags with a per-flag clear strobe. In multiprocessor wake-up mode the block drops every received frame until one arrives with its multiprocessor bit at 1. That frame is processed normally, and hardware clears the wake-up mode bit.

Top module: `sio_ctrl_gate`

## Requirements
- R1: All eight control bits reset to 0. A write with `reg_wr` high appears on `reg_rdata` one clock later. Bit positions, from MSB to LSB: 7 transmit-irq enable, 6 receive-irq enable, 5 transmit enable, 4 receive enable, 3 wake-up mode, 2 transmit-end-irq enable, 1 clock select high, 0 clock select low.
- R2: `irq_txi` is high exactly when bit 7 and `tx_empty` are both 1.
- R3: `irq_tei` is high exactly when bit 2 and `tx_end` are both 1.
- R4: `tx_en` follows bit 5 and `rx_en` follows bit 4.
- R5: An accepted frame (`rx_done` high) sets flags one clock later. It sets `fer` if `rx_frame_err` is high, sets `orer` if `rx_overrun` is high, and sets `rdrf` if neither error is present. While `rx_en` is 0, `rx_done` is ignored.
- R6: `flag_clr` bit 0 clears `rdrf`, bit 1 clears `fer`, and bit 2 clears `orer`, one clock later. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R7: `irq_rxi` is bit 6 AND `rdrf`. `irq_eri` is bit 6 AND (`fer` OR `orer`). Both are held low while bit 3 is 1.
- R8: While bit 3 is 1, a frame whose `rx_mpb` is 0 changes no flag.
- R9: While bit 3 is 1, a frame with `rx_mpb` of 1 clears bit 3 one clock later and sets its flags as in R5.
- R10: A bus write in the same cycle as a hardware clear of bit 3 wins: the written value is stored.
- R11: With `sync_mode` 0, clock select 00 gives the internal clock with the pin not driven. Select 01 gives the internal clock with `clk_pin_drive` high. Select 1x gives the external clock with `clk_src_ext` and `clk_ext_x16` high.
- R12: With `sync_mode` 1, clock select high bit 0 gives the internal clock with `clk_pin_drive` high. Clock select high bit 1 gives the external clock with `clk_ext_x16` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Current control word |
| rx_done | input | 1 | Receiver frame-complete strobe |
| rx_frame_err | input | 1 | Framing error for this frame |
| rx_overrun | input | 1 | Overrun for this frame |
| rx_mpb | input | 1 | Multiprocessor bit of this frame |
| flag_clr | input | 3 | Flag clear strobes {orer, fer, rdrf} |
| tx_empty | input | 1 | Transmit data register empty |
| tx_end | input | 1 | Transmission finished |
| sync_mode | input | 1 | 1 = clocked synchronous framing |
| rdrf | output | 1 | Receive data ready flag |
| fer | output | 1 | Framing error flag |
| orer | output | 1 | Overrun flag |
| irq_txi | output | 1 | Transmit-data-empty request |
| irq_rxi | output | 1 | Receive-data-full request |
| irq_eri | output | 1 | Receive-error request |
| irq_tei | output | 1 | Transmit-end request |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| clk_src_ext | output | 1 | External clock selected |
| clk_pin_drive | output | 1 | Clock pin drives a clock out |
| clk_ext_x16 | output | 1 | External clock runs at 16x bit rate |

## Verification
Control word writes and flag sets or clears take effect one clock after the edge that samples them. Enables, clock selection and interrupt requests are combinational from those registers and from the transmitter levels, so they are valid in the same cycle as the register update. The bench changes every input 2 ns after a rising edge and samples all outputs at that same point after the next edge. Each check therefore observes the result of exactly one registered step.

// File: rtl/sio_ctrl_pkg.sv
package sio_ctrl_pkg;
  localparam int unsigned CR_W  = 8;
  localparam int unsigned NFLAG = 3;

  typedef struct packed {
    logic tie;
    logic rie;
    logic te;
    logic re;
    logic mpie;
    logic teie;
    logic cke1;
    logic cke0;
  } ctrl_t;

  typedef struct packed {
    logic orer;
    logic fer;
    logic rdrf;
  } rx_flags_t;
endpackage

// File: rtl/sio_rst_sync.sv
module sio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/sio_ctl_reg.sv
module sio_ctl_reg
  import sio_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CR_W-1:0] wdata,
  input  logic            mp_hit,
  output ctrl_t           ctrl
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  ld;

  always_comb begin
    ctrl_d = ctrl_q;
    ld     = wr_en | mp_hit;
    if (wr_en) begin
      ctrl_d = ctrl_t'(wdata);
    end else if (mp_hit) begin
      ctrl_d.mpie = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (ld) ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/sio_rx_status.sv
module sio_rx_status
  import sio_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             frame_err,
  input  logic             overrun,
  input  logic [NFLAG-1:0] clr,
  output rx_flags_t        flags
);
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] flag_q;

  always_comb begin
    set_v = '0;
    if (take) begin
      set_v = {overrun, frame_err, ~(frame_err | overrun)};
    end
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic en;
    logic nxt;
    always_comb begin
      en  = set_v[g] | clr[g];
      nxt = set_v[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flag_q[g] <= 1'b0;
      else if (en) flag_q[g] <= nxt;
    end
  end

  assign flags = rx_flags_t'(flag_q);
endmodule

// File: rtl/sio_irq_gate.sv
module sio_irq_gate (
  input  logic tie,
  input  logic rie,
  input  logic teie,
  input  logic mpie,
  input  logic rdrf,
  input  logic fer,
  input  logic orer,
  input  logic tx_empty,
  input  logic tx_end,
  output logic irq_txi,
  output logic irq_rxi,
  output logic irq_eri,
  output logic irq_tei
);
  logic rx_gate;

  always_comb begin
    rx_gate = rie & ~mpie;
    irq_txi = tie & tx_empty;
    irq_tei = teie & tx_end;
    irq_rxi = rx_gate & rdrf;
    irq_eri = rx_gate & (fer | orer);
  end
endmodule

// File: rtl/sio_clk_sel.sv
module sio_clk_sel (
  input  logic sync_mode,
  input  logic cke1,
  input  logic cke0,
  output logic src_ext,
  output logic pin_drive,
  output logic ext_x16
);
  always_comb begin
    src_ext = cke1;
    if (sync_mode) begin
      pin_drive = ~cke1;
      ext_x16   = 1'b0;
    end else begin
      pin_drive = ~cke1 & cke0;
      ext_x16   = cke1;
    end
  end
endmodule

// File: rtl/sio_ctrl_gate.sv
module sio_ctrl_gate
  import sio_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [CR_W-1:0]  reg_wdata,
  output logic [CR_W-1:0]  reg_rdata,
  input  logic             rx_done,
  input  logic             rx_frame_err,
  input  logic             rx_overrun,
  input  logic             rx_mpb,
  input  logic [NFLAG-1:0] flag_clr,
  input  logic             tx_empty,
  input  logic             tx_end,
  input  logic             sync_mode,
  output logic             rdrf,
  output logic             fer,
  output logic             orer,
  output logic             irq_txi,
  output logic             irq_rxi,
  output logic             irq_eri,
  output logic             irq_tei,
  output logic             tx_en,
  output logic             rx_en,
  output logic             clk_src_ext,
  output logic             clk_pin_drive,
  output logic             clk_ext_x16
);
  logic      rst_sync_n;
  ctrl_t     ctrl;
  rx_flags_t flags;
  logic      rx_live;
  logic      rx_take;
  logic      mp_hit;

  sio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    rx_live = rx_done & ctrl.re;
    rx_take = rx_live & (~ctrl.mpie | rx_mpb);
    mp_hit  = rx_live & ctrl.mpie & rx_mpb;
  end

  sio_ctl_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (reg_wr),
    .wdata  (reg_wdata),
    .mp_hit (mp_hit),
    .ctrl   (ctrl)
  );

  sio_rx_status u_stat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .take      (rx_take),
    .frame_err (rx_frame_err),
    .overrun   (rx_overrun),
    .clr       (flag_clr),
    .flags     (flags)
  );

  sio_irq_gate u_irq (
    .tie      (ctrl.tie),
    .rie      (ctrl.rie),
    .teie     (ctrl.teie),
    .mpie     (ctrl.mpie),
    .rdrf     (flags.rdrf),
    .fer      (flags.fer),
    .orer     (flags.orer),
    .tx_empty (tx_empty),
    .tx_end   (tx_end),
    .irq_txi  (irq_txi),
    .irq_rxi  (irq_rxi),
    .irq_eri  (irq_eri),
    .irq_tei  (irq_tei)
  );

  sio_clk_sel u_clk (
    .sync_mode (sync_mode),
    .cke1      (ctrl.cke1),
    .cke0      (ctrl.cke0),
    .src_ext   (clk_src_ext),
    .pin_drive (clk_pin_drive),
    .ext_x16   (clk_ext_x16)
  );

  assign reg_rdata = ctrl;
  assign rdrf      = flags.rdrf;
  assign fer       = flags.fer;
  assign orer      = flags.orer;
  assign tx_en     = ctrl.te;
  assign rx_en     = ctrl.re;
endmodule

// File: rtl/sio_ctrl_gate_chk.sv
module sio_ctrl_gate_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       rx_done,
  input logic       rx_mpb,
  input logic [2:0] flag_clr,
  input logic       tx_empty,
  input logic       tx_end,
  input logic       rdrf,
  input logic       fer,
  input logic       orer,
  input logic       irq_txi,
  input logic       irq_rxi,
  input logic       irq_tei,
  input logic       tx_en,
  input logic       rx_en
);
  assert_wr_visible_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr |=> reg_rdata == $past(reg_wdata));

  assert_txi_gate_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_txi == (reg_rdata[7] & tx_empty));

  assert_tei_gate_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_tei == (reg_rdata[2] & tx_end));

  assert_enables_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_en == reg_rdata[5]) && (rx_en == reg_rdata[4]));

  assert_rxi_needs_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_rxi |-> (rdrf && reg_rdata[6] && !reg_rdata[3]));

  assert_mp_filter_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_rdata[3] && !rx_mpb && flag_clr == 3'b000)
      |=> $stable({rdrf, fer, orer}));

  assert_mp_wake_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_rdata[3] && rx_done && rx_en && rx_mpb && !reg_wr) |=> !reg_rdata[3]);

  assert_wr_wins_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_rdata[3] && rx_done && rx_en && rx_mpb && reg_wr)
      |=> reg_rdata[3] == $past(reg_wdata[3]));
endmodule

bind sio_ctrl_gate sio_ctrl_gate_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .rx_done    (rx_done),
  .rx_mpb     (rx_mpb),
  .flag_clr   (flag_clr),
  .tx_empty   (tx_empty),
  .tx_end     (tx_end),
  .rdrf       (rdrf),
  .fer        (fer),
  .orer       (orer),
  .irq_txi    (irq_txi),
  .irq_rxi    (irq_rxi),
  .irq_tei    (irq_tei),
  .tx_en      (tx_en),
  .rx_en      (rx_en)
);

// File: tb/sio_ctrl_gate_tb.sv
module sio_ctrl_gate_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       rx_done, rx_frame_err, rx_overrun, rx_mpb;
  logic [2:0] flag_clr;
  logic       tx_empty, tx_end, sync_mode;
  logic       rdrf, fer, orer;
  logic       irq_txi, irq_rxi, irq_eri, irq_tei;
  logic       tx_en, rx_en;
  logic       clk_src_ext, clk_pin_drive, clk_ext_x16;

  int nvec  = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  sio_ctrl_gate u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_done(rx_done), .rx_frame_err(rx_frame_err),
    .rx_overrun(rx_overrun), .rx_mpb(rx_mpb), .flag_clr(flag_clr),
    .tx_empty(tx_empty), .tx_end(tx_end), .sync_mode(sync_mode),
    .rdrf(rdrf), .fer(fer), .orer(orer), .irq_txi(irq_txi),
    .irq_rxi(irq_rxi), .irq_eri(irq_eri), .irq_tei(irq_tei),
    .tx_en(tx_en), .rx_en(rx_en), .clk_src_ext(clk_src_ext),
    .clk_pin_drive(clk_pin_drive), .clk_ext_x16(clk_ext_x16)
  );

  // {wdata[7:0], tx_empty, tx_end, sync_mode, exp{txi,tei,te,re,ext,drv,x16}}
  localparam int NV = 15;
  localparam logic [17:0] VEC [0:NV-1] = '{
    {8'h80, 1'b1, 1'b0, 1'b0, 7'b1000000},
    {8'h80, 1'b0, 1'b1, 1'b0, 7'b0000000},
    {8'h04, 1'b0, 1'b1, 1'b0, 7'b0100000},
    {8'h04, 1'b1, 1'b0, 1'b0, 7'b0000000},
    {8'h20, 1'b1, 1'b1, 1'b0, 7'b0010000},
    {8'h10, 1'b0, 1'b0, 1'b0, 7'b0001000},
    {8'h01, 1'b0, 1'b0, 1'b0, 7'b0000010},
    {8'h02, 1'b0, 1'b0, 1'b0, 7'b0000101},
    {8'h03, 1'b0, 1'b0, 1'b0, 7'b0000101},
    {8'h00, 1'b0, 1'b0, 1'b1, 7'b0000010},
    {8'h01, 1'b0, 1'b0, 1'b1, 7'b0000010},
    {8'h02, 1'b0, 1'b0, 1'b1, 7'b0000100},
    {8'h03, 1'b0, 1'b0, 1'b1, 7'b0000100},
    {8'hA4, 1'b1, 1'b1, 1'b0, 7'b1110000},
    {8'h00, 1'b1, 1'b1, 1'b0, 7'b0000000}
  };

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic frame(input logic fe, input logic ov, input logic mpb);
    rx_done = 1'b1; rx_frame_err = fe; rx_overrun = ov; rx_mpb = mpb;
    cyc();
    rx_done = 1'b0; rx_frame_err = 1'b0; rx_overrun = 1'b0; rx_mpb = 1'b0;
  endtask

  task automatic clr(input logic [2:0] c);
    flag_clr = c;
    cyc();
    flag_clr = 3'b000;
  endtask

  function automatic logic [7:0] fl();
    return {5'b0, orer, fer, rdrf};
  endfunction

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rx_done = 1'b0; rx_frame_err = 1'b0; rx_overrun = 1'b0; rx_mpb = 1'b0;
    flag_clr = '0; tx_empty = 1'b1; tx_end = 1'b1; sync_mode = 1'b0;
    repeat (3) cyc();
    chk("R1", "reset word", reg_rdata, 8'h00);
    chk("R1", "reset flags", fl(), 8'h00);
    chk("R1", "reset irqs", {4'b0, irq_txi, irq_rxi, irq_eri, irq_tei}, 8'h00);
    rst_n = 1'b1;
    repeat (3) cyc();

    // table walk: writes plus transmitter levels and clock mode
    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      tx_empty = v[9]; tx_end = v[8]; sync_mode = v[7];
      wr(v[17:10]);
      chk("R1", "readback", reg_rdata, v[17:10]);
      chk("R2", "irq_txi", {7'b0, irq_txi}, {7'b0, v[6]});
      chk("R3", "irq_tei", {7'b0, irq_tei}, {7'b0, v[5]});
      chk("R4", "te/re", {6'b0, tx_en, rx_en}, {6'b0, v[4:3]});
      if (v[7]) chk("R12", "sync clk", {5'b0, clk_src_ext, clk_pin_drive, clk_ext_x16}, {5'b0, v[2:0]});
      else      chk("R11", "async clk", {5'b0, clk_src_ext, clk_pin_drive, clk_ext_x16}, {5'b0, v[2:0]});
    end
    tx_empty = 1'b0; tx_end = 1'b0; sync_mode = 1'b0;

    // receive flags and gating
    wr(8'h50);
    frame(1'b0, 1'b0, 1'b0);
    chk("R5", "clean frame flags", fl(), 8'h01);
    chk("R7", "rxi/eri", {6'b0, irq_rxi, irq_eri}, 8'h02);
    clr(3'b001);
    chk("R6", "clear rdrf", fl(), 8'h00);
    frame(1'b1, 1'b0, 1'b0);
    chk("R5", "framing flags", fl(), 8'h02);
    chk("R7", "eri", {6'b0, irq_rxi, irq_eri}, 8'h01);
    flag_clr = 3'b010; frame(1'b0, 1'b1, 1'b0); flag_clr = 3'b000;
    chk("R6", "clear fer, set orer", fl(), 8'h04);
    flag_clr = 3'b100; frame(1'b0, 1'b0, 1'b0); flag_clr = 3'b000;
    chk("R6", "clear orer, set rdrf", fl(), 8'h01);
    flag_clr = 3'b001; frame(1'b0, 1'b0, 1'b0); flag_clr = 3'b000;
    chk("R6", "set beats clear", fl(), 8'h01);
    clr(3'b001);
    chk("R6", "clear alone", fl(), 8'h00);

    wr(8'h40);
    frame(1'b0, 1'b0, 1'b0);
    chk("R5", "ignored while rx off", fl(), 8'h00);

    wr(8'h10);
    frame(1'b0, 1'b0, 1'b0);
    chk("R5", "flag with rie off", fl(), 8'h01);
    chk("R7", "rxi masked by rie", {7'b0, irq_rxi}, 8'h00);
    clr(3'b001);

    // wake-up filtering
    wr(8'h58);
    frame(1'b0, 1'b0, 1'b0);
    chk("R8", "mpb0 frame dropped", fl(), 8'h00);
    frame(1'b1, 1'b1, 1'b0);
    chk("R8", "mpb0 error dropped", fl(), 8'h00);
    chk("R8", "mode kept", reg_rdata, 8'h58);
    frame(1'b0, 1'b0, 1'b1);
    chk("R9", "mode auto-cleared", reg_rdata, 8'h50);
    chk("R9", "wake frame flags", fl(), 8'h01);
    chk("R9", "wake frame rxi", {7'b0, irq_rxi}, 8'h01);

    wr(8'h58);
    chk("R7", "rxi held in mode", {7'b0, irq_rxi}, 8'h00);
    chk("R7", "flag still set", fl(), 8'h01);
    clr(3'b001);

    // write collides with hardware clear
    reg_wr = 1'b1; reg_wdata = 8'h5C;
    frame(1'b0, 1'b0, 1'b1);
    reg_wr = 1'b0;
    chk("R10", "write wins", reg_rdata, 8'h5C);
    chk("R10", "frame still taken", fl(), 8'h01);
    wr(8'h50);
    chk("R1", "software clear of mode", reg_rdata, 8'h50);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule